// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects 32 level-sensitive interrupt request lines and sorts each into one of three classes. A line flagged as fast drives the fast-interrupt output. Any other enabled line drives the normal-interrupt output. A normal line is called vectored when at least one of the 16 priority slots is enabled and points at it; otherwise it is a non-vectored line. Both processor outputs are registered, so an input change shows up one clock later.

The host reads and writes the block through a small synchronous register port. Writes take effect on the clock edge. Reads are combinational from the stored state. Each slot holds an enable bit, a source number and a service address. The vector register returns the service address of the lowest-numbered slot that matches an active normal request. When no slot matches, it returns a shared default address. All status words and the vector value are snapshots taken on the same edge that updates the two outputs.

Top module: `intr_vector_ctrl`

## Requirements
- R1: After an asynchronous active-low reset, both outputs are low and every readable register returns zero.
- R2: `fiqOut` is high in the cycle after an input that is enabled (bit set at address 0x00) and fast-classed (bit set at address 0x01) is high, and is low otherwise.
- R3: Address 0x05 reads the snapshot of requests that are enabled and fast-classed, one bit per source.
- R4: `irqOut` is high in the cycle after any enabled input that is not fast-classed is high; a disabled input has no effect.
- R5: Address 0x06 reads the snapshot of requests that are enabled and not fast-classed, one bit per source.
- R6: A fast-classed source never appears in the normal status word, never raises `irqOut`, and never selects a slot address.
- R7: Slot n (0..15) has a control word at address 0x10+n, with bit 5 as the enable and bits 4:0 as the source number. Its service address is at 0x20+n. Both read back as written, with the unused bits reading zero.
- R8: Address 0x07 returns the service address of the lowest-numbered enabled slot whose source is an active normal request. Slot 0 has the highest priority.
- R9: A slot whose enable bit is clear never matches, even if its source is active.
- R10: When no slot matches, address 0x07 returns the default address held at 0x08. This includes the case where only non-vectored requests are active.
- R11: Address 0x04 reads the snapshot of the raw inputs. Addresses 0x00, 0x01 and 0x08 read back as written. Unmapped addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 32 | Level-sensitive interrupt requests |
| regAddr | input | 6 | Register address |
| regWrEn | input | 1 | Write strobe for the current address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the current address |
| fiqOut | output | 1 | Fast interrupt to the processor |
| irqOut | output | 1 | Normal interrupt to the processor |

## Verification
A corrupted class or enable bit shows up on `fiqOut` or `irqOut` one cycle after a request on that source arrives. A wrong slot enable, source or address shows up as a wrong value at address 0x07 on the next read after that slot's source becomes active. A priority error appears only when two matching slots are active at the same time, so the stimulus deliberately overlaps slot sources. Because a behavioural model runs alongside the design and is compared every cycle, any divergence is reported within one clock of the snapshot that exposes it.

// File: rtl/intr_vector_pkg.sv
package intr_vector_pkg;
  localparam int NUM_SRC    = 32;
  localparam int NUM_SLOT   = 16;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 6;
  localparam int SRC_W      = $clog2(NUM_SRC);
  localparam int SLOT_IDX_W = $clog2(NUM_SLOT);

  localparam logic [ADDR_W-1:0] ADR_ENABLE   = 6'h00;
  localparam logic [ADDR_W-1:0] ADR_FASTSEL  = 6'h01;
  localparam logic [ADDR_W-1:0] ADR_RAW      = 6'h04;
  localparam logic [ADDR_W-1:0] ADR_FASTSTAT = 6'h05;
  localparam logic [ADDR_W-1:0] ADR_NORMSTAT = 6'h06;
  localparam logic [ADDR_W-1:0] ADR_VECT     = 6'h07;
  localparam logic [ADDR_W-1:0] ADR_DEFAULT  = 6'h08;
  localparam logic [1:0]        PAGE_SLOTCTL = 2'b01;
  localparam logic [1:0]        PAGE_SLOTADR = 2'b10;

  typedef enum logic [3:0] {
    RD_NONE, RD_ENABLE, RD_FASTSEL, RD_RAW, RD_FASTSTAT,
    RD_NORMSTAT, RD_VECT, RD_DEFAULT, RD_SLOTCTL, RD_SLOTADR
  } rdSel_t;

  typedef struct packed {
    logic                  wrEnable;
    logic                  wrFastSel;
    logic                  wrDefault;
    logic                  wrSlotCtl;
    logic                  wrSlotAdr;
    logic [SLOT_IDX_W-1:0] slotIdx;
    rdSel_t                rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/intr_vector_decode.sv
module intr_vector_decode
  import intr_vector_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobe_t       strobe
);
  localparam int PAGE_LSB = ADDR_W - 2;

  logic [1:0] page;
  assign page = regAddr[ADDR_W-1:PAGE_LSB];

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    strobe.slotIdx = regAddr[SLOT_IDX_W-1:0];
    if (page == PAGE_SLOTCTL) begin
      strobe.rdSel = RD_SLOTCTL;
      strobe.wrSlotCtl = regWrEn;
    end else if (page == PAGE_SLOTADR) begin
      strobe.rdSel = RD_SLOTADR;
      strobe.wrSlotAdr = regWrEn;
    end else begin
      case (regAddr)
        ADR_ENABLE:   begin strobe.rdSel = RD_ENABLE;  strobe.wrEnable  = regWrEn; end
        ADR_FASTSEL:  begin strobe.rdSel = RD_FASTSEL; strobe.wrFastSel = regWrEn; end
        ADR_DEFAULT:  begin strobe.rdSel = RD_DEFAULT; strobe.wrDefault = regWrEn; end
        ADR_RAW:      strobe.rdSel = RD_RAW;
        ADR_FASTSTAT: strobe.rdSel = RD_FASTSTAT;
        ADR_NORMSTAT: strobe.rdSel = RD_NORMSTAT;
        ADR_VECT:     strobe.rdSel = RD_VECT;
        default:      strobe.rdSel = RD_NONE;
      endcase
    end
  end

  // R11: a single cycle never writes two registers
  assert_single_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrEnable, strobe.wrFastSel, strobe.wrDefault,
              strobe.wrSlotCtl, strobe.wrSlotAdr}));

  // R11: writes follow the write strobe only
  assert_no_stray_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> !(strobe.wrEnable | strobe.wrFastSel | strobe.wrDefault |
                   strobe.wrSlotCtl | strobe.wrSlotAdr));
endmodule

// File: rtl/intr_vector_datapath.sv
module intr_vector_datapath
  import intr_vector_pkg::*;
#(
  parameter int NSRC  = NUM_SRC,
  parameter int NSLOT = NUM_SLOT,
  parameter int DW    = DATA_W,
  parameter int SW    = SRC_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] reqIn,
  input  ctrlStrobe_t     strobe,
  input  logic [DW-1:0]   wrData,
  output logic [DW-1:0]   rdData,
  output logic            fiqOut,
  output logic            irqOut
);
  localparam int CTL_PAD = DW - SW - 1;
  localparam int SRC_PAD = DW - NSRC;

  logic [NSRC-1:0]  enableReg, fastSelReg;
  logic [DW-1:0]    defaultAddrReg;
  logic [NSLOT-1:0] slotEnReg;
  logic [SW-1:0]    slotSrcReg  [NSLOT];
  logic [DW-1:0]    slotAddrReg [NSLOT];

  logic [NSRC-1:0]  fastLive, normLive;
  logic [NSLOT-1:0] slotHit;
  logic [DW-1:0]    vectNext;

  logic [NSRC-1:0]  rawSnap, fastSnap, normSnap;
  logic [DW-1:0]    vectSnap;
  logic             fiqQ, irqQ;

  // Global configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg      <= '0;
      fastSelReg     <= '0;
      defaultAddrReg <= '0;
    end else begin
      if (strobe.wrEnable)  enableReg      <= wrData[NSRC-1:0];
      if (strobe.wrFastSel) fastSelReg     <= wrData[NSRC-1:0];
      if (strobe.wrDefault) defaultAddrReg <= wrData;
    end
  end

  // Class routing: fast lines are removed from the normal side
  assign fastLive = reqIn & enableReg & fastSelReg;
  assign normLive = reqIn & enableReg & ~fastSelReg;

  // One register set and one matcher per slot
  for (genvar g = 0; g < NSLOT; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotEnReg[g]   <= 1'b0;
        slotSrcReg[g]  <= '0;
        slotAddrReg[g] <= '0;
      end else begin
        if (strobe.wrSlotCtl && strobe.slotIdx == g[SLOT_IDX_W-1:0]) begin
          slotEnReg[g]  <= wrData[SW];
          slotSrcReg[g] <= wrData[SW-1:0];
        end
        if (strobe.wrSlotAdr && strobe.slotIdx == g[SLOT_IDX_W-1:0])
          slotAddrReg[g] <= wrData;
      end
    end

    assign slotHit[g] = slotEnReg[g] & normLive[slotSrcReg[g]];

    // R9: a disabled slot never matches
    assert_disabled_slot_R9: assert property (@(posedge clk) disable iff (!rstN)
      !slotEnReg[g] |-> !slotHit[g]);
  end

  // Fixed priority: the lowest slot index wins
  always_comb begin
    vectNext = defaultAddrReg;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (slotHit[i]) vectNext = slotAddrReg[i];
    end
  end

  // Snapshot and output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawSnap  <= '0;
      fastSnap <= '0;
      normSnap <= '0;
      vectSnap <= '0;
      fiqQ     <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      rawSnap  <= reqIn;
      fastSnap <= fastLive;
      normSnap <= normLive;
      vectSnap <= vectNext;
      fiqQ     <= |fastLive;
      irqQ     <= |normLive;
    end
  end

  assign fiqOut = fiqQ;
  assign irqOut = irqQ;

  // Read multiplexer
  always_comb begin
    case (strobe.rdSel)
      RD_ENABLE:   rdData = {{SRC_PAD{1'b0}}, enableReg};
      RD_FASTSEL:  rdData = {{SRC_PAD{1'b0}}, fastSelReg};
      RD_RAW:      rdData = {{SRC_PAD{1'b0}}, rawSnap};
      RD_FASTSTAT: rdData = {{SRC_PAD{1'b0}}, fastSnap};
      RD_NORMSTAT: rdData = {{SRC_PAD{1'b0}}, normSnap};
      RD_VECT:     rdData = vectSnap;
      RD_DEFAULT:  rdData = defaultAddrReg;
      RD_SLOTCTL:  rdData = {{CTL_PAD{1'b0}}, slotEnReg[strobe.slotIdx],
                             slotSrcReg[strobe.slotIdx]};
      RD_SLOTADR:  rdData = slotAddrReg[strobe.slotIdx];
      default:     rdData = '0;
    endcase
  end

  // R2: fast output follows enabled fast requests one cycle later
  assert_fiq_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> fiqOut == $past(|(reqIn & enableReg & fastSelReg)));

  // R4: normal output follows enabled non-fast requests one cycle later
  assert_irq_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqOut == $past(|(reqIn & enableReg & ~fastSelReg)));

  // R6: no source is in both status words
  assert_class_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fastSnap & normSnap) == '0);

  // R10: the default address is captured when no slot matches
  assert_vect_default_R10: assert property (@(posedge clk) disable iff (!rstN)
    (slotHit == '0) |=> vectSnap == $past(defaultAddrReg));

  // R8: a match always raises the normal output next cycle
  assert_hit_implies_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    (slotHit != '0) |=> irqOut);
endmodule

// File: rtl/intr_vector_ctrl.sv
module intr_vector_ctrl
  import intr_vector_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               fiqOut,
  output logic               irqOut
);
  ctrlStrobe_t strobe;

  intr_vector_decode u_decode (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  intr_vector_datapath #(
    .NSRC  (NUM_SRC),
    .NSLOT (NUM_SLOT),
    .DW    (DATA_W),
    .SW    (SRC_W)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .reqIn  (reqIn),
    .strobe (strobe),
    .wrData (regWrData),
    .rdData (regRdData),
    .fiqOut (fiqOut),
    .irqOut (irqOut)
  );
endmodule

// File: tb/intr_vector_ctrl_tb.sv
`timescale 1ns/100ps
module intr_vector_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] reqIn = '0;
  logic [5:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        fiqOut, irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intr_vector_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .fiqOut(fiqOut), .irqOut(irqOut)
  );

  // Behavioural reference model
  logic [31:0] mEn, mFast, mDef, mRaw, mFastS, mNormS, mVect;
  bit          mSlotEn [16];
  int          mSlotSrc [16];
  logic [31:0] mSlotAddr [16];
  bit          mFiq, mIrq;

  always @(posedge clk or negedge rstN) begin : model
    logic [31:0] fl, nl, v;
    bit found;
    if (!rstN) begin
      mEn = 0; mFast = 0; mDef = 0; mRaw = 0; mFastS = 0; mNormS = 0; mVect = 0;
      mFiq = 0; mIrq = 0;
      for (int s = 0; s < 16; s++) begin
        mSlotEn[s] = 0; mSlotSrc[s] = 0; mSlotAddr[s] = 0;
      end
    end else begin
      fl = reqIn & mEn & mFast;
      nl = reqIn & mEn & ~mFast;
      v = mDef;
      found = 0;
      for (int s = 0; s < 16; s++)
        if (!found && mSlotEn[s] && nl[mSlotSrc[s]]) begin
          v = mSlotAddr[s];
          found = 1;
        end
      mRaw = reqIn; mFastS = fl; mNormS = nl; mVect = v;
      mFiq = (fl != 0); mIrq = (nl != 0);
      if (regWrEn) begin
        if (regAddr == 6'h00) mEn = regWrData;
        else if (regAddr == 6'h01) mFast = regWrData;
        else if (regAddr == 6'h08) mDef = regWrData;
        else if (regAddr[5:4] == 2'b01) begin
          mSlotEn[regAddr[3:0]] = regWrData[5];
          mSlotSrc[regAddr[3:0]] = int'(regWrData[4:0]);
        end else if (regAddr[5:4] == 2'b10)
          mSlotAddr[regAddr[3:0]] = regWrData;
      end
    end
  end

  function automatic logic [31:0] modelRead(logic [5:0] a);
    if (a[5:4] == 2'b01) return {26'd0, mSlotEn[a[3:0]], 5'(mSlotSrc[a[3:0]])};
    if (a[5:4] == 2'b10) return mSlotAddr[a[3:0]];
    case (a)
      6'h00: return mEn;
      6'h01: return mFast;
      6'h04: return mRaw;
      6'h05: return mFastS;
      6'h06: return mNormS;
      6'h07: return mVect;
      6'h08: return mDef;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagFor(logic [5:0] a);
    if (a[5:4] == 2'b01 || a[5:4] == 2'b10) return "R7";
    case (a)
      6'h05: return "R3";
      6'h06: return "R5";
      6'h07: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2", {31'd0, fiqOut}, {31'd0, mFiq});
      chk("R4", {31'd0, irqOut}, {31'd0, mIrq});
      chk(tagFor(regAddr), regRdData, modelRead(regAddr));
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(string tag, logic [5:0] a, logic [31:0] exp);
    regAddr = a;
    #0.5;
    chk(tag, regRdData, exp);
  endtask

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    step();
    // R1: reset state
    chk("R1", {30'd0, fiqOut, irqOut}, 32'd0);
    rdChk("R1", 6'h07, 32'd0);
    rdChk("R1", 6'h00, 32'd0);
    step();
    rstN = 1'b1;
    step();

    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h01, 32'h0000_0003);
    wr(6'h08, 32'hDEAD_0000);
    rdChk("R11", 6'h08, 32'hDEAD_0000);

    // R2 / R3: fast request
    reqIn = 32'h1;
    step();
    chk("R2", {31'd0, fiqOut}, 32'd1);
    chk("R6", {31'd0, irqOut}, 32'd0);
    rdChk("R3", 6'h05, 32'h1);
    rdChk("R6", 6'h06, 32'h0);

    // R10: only non-vectored request active
    reqIn = 32'h20;
    step();
    chk("R4", {31'd0, irqOut}, 32'd1);
    rdChk("R5", 6'h06, 32'h20);
    rdChk("R10", 6'h07, 32'hDEAD_0000);

    // R7 / R9 / R8: slot setup
    wr(6'h13, 32'h25);          // slot 3: enable, source 5
    wr(6'h23, 32'h1000_0300);
    wr(6'h11, 32'h29);          // slot 1: enable, source 9
    wr(6'h21, 32'h1000_0100);
    wr(6'h10, 32'h05);          // slot 0: disabled, source 5
    wr(6'h20, 32'h0000_0BAD);
    rdChk("R7", 6'h13, 32'h25);
    rdChk("R7", 6'h10, 32'h05);
    rdChk("R7", 6'h21, 32'h1000_0100);
    step();
    rdChk("R9", 6'h07, 32'h1000_0300);
    reqIn = 32'h220;
    step();
    rdChk("R8", 6'h07, 32'h1000_0100);

    // R6: a fast source pointed to by a slot
    wr(6'h12, 32'h21);          // slot 2: enable, source 1 (fast)
    wr(6'h22, 32'h0000_0222);
    reqIn = 32'h2;
    step();
    chk("R6", {31'd0, fiqOut}, 32'd1);
    chk("R6", {31'd0, irqOut}, 32'd0);
    rdChk("R6", 6'h07, 32'hDEAD_0000);

    // R4: a disabled source has no effect
    wr(6'h00, ~32'h200);
    reqIn = 32'h200;
    step();
    chk("R4", {31'd0, irqOut}, 32'd0);
    rdChk("R10", 6'h07, 32'hDEAD_0000);

    // R11: unmapped address ignores writes and reads zero
    wr(6'h0C, 32'hFFFF_FFFF);
    rdChk("R11", 6'h0C, 32'h0);
    rdChk("R11", 6'h04, 32'h200);

    // Random traffic compared with the model each cycle
    for (int n = 0; n < 3000; n++) begin
      reqIn = $urandom;
      if (($urandom % 4) == 0) reqIn = reqIn & 32'h0000_0F0F;
      regAddr = 6'($urandom);
      regWrData = $urandom;
      regWrEn = (($urandom % 6) == 0);
      step();
    end
    regWrEn = 1'b0;
    step();
    finishRun();
  end
endmodule